// File: doc/BRIEF.md
# Beacon Timing Timer Bank

This block holds four 16-bit beacon schedule timers and compares each one with the time-unit (TU) value of the local timing synchronisation counter. Timer 0 holds the next beacon target time. Timer 1 holds the DMA beacon alert. Timer 2 holds the software beacon alert. Timer 3 marks where the ATIM window ends. Timers 1 and 2 carry three extra low-order bits, so they count in eighths of a TU. Their TU part is bits [18:3].

A timer fires only on an exact match with the TU input. When it fires, it moves forward by one beacon interval. If the counter jumps past a timer, that timer keeps its value until the 16-bit TU value wraps around to it again. After such a jump the timers can drift apart. A wrap-aware consistency flag reports this drift, so software can reprogram the bank.

Timers are set in one of two ways. A per-timer write loads one timer. A program strobe takes a next-beacon value and derives all four timers from it, using rules that depend on the operating mode.

Top module: `beacon_timer_bank`

## Requirements
- R1: While reset is asserted, all four timers read zero. With the enable low, no event is raised.
- R2: With the enable high, `evt[i]` is high in the same cycle that `tsf_tu` equals timer i's TU value. The TU value is the whole value for timers 0 and 3, and bits [18:3] for timers 1 and 2. At the next clock edge the timer grows by `bcn_ivl`, or by `bcn_ivl*8` for timers 1 and 2.
- R3: A timer whose TU value differs from `tsf_tu` keeps its value and raises no event. This holds even when `tsf_tu` has jumped beyond the timer.
- R4: Advancing wraps modulo 2^16 for timers 0 and 3, and modulo 2^19 for timers 1 and 2.
- R5: While `enable` is low, no event is raised and no timer advances. Writes and program strobes still load the timers.
- R6: `wr_en[i]` loads timer i from `wr_data` at the next edge. Timers 0 and 3 take bits [15:0]. A write takes priority over an advance in the same cycle.
- R7: A program strobe with `sta_mode`=0 sets timer 0 to N and timer 3 to N+1. It sets timer 1 to (N-DMA_LEAD)<<3 and timer 2 to (N-SW_LEAD)<<3. N is `prog_nbtt` and the arithmetic wraps.
- R8: A program strobe with `sta_mode`=1 sets timers 0 and 3 as in R7, timer 1 to 0x0FFFF and timer 2 to 0x7FFFF.
- R9: A program strobe takes priority over any write or advance in the same cycle.
- R10: `win_ok` is high when both timer pairs pass the window test described below, given the current timers and `bcn_ivl`.
  - The first pair is A=timer 0, B=timer 3, with window 1.
  - The second pair is A=timer1>>3, B=timer 0, with window DMA_LEAD.
  - A pair passes when any one of these holds: B-A equals the window; A-B equals interval-window; (A|0x10000)-B equals interval-window; (B|0x10000)-A equals the window.
- R11: Suppose `tsf_tu` jumps so that timer 3 advances while timer 0 is left behind. Then `win_ok` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows events and advancing |
| sta_mode | input | 1 | 1: station/monitor rules for program strobe; 0: access point/ad hoc rules |
| bcn_ivl | input | 16 | Beacon interval in TU |
| tsf_tu | input | 16 | Current counter value in TU |
| wr_en | input | 4 | Per-timer write strobe, bit i = timer i |
| wr_data | input | 19 | Write value |
| prog_en | input | 1 | Program all timers from `prog_nbtt` |
| prog_nbtt | input | 16 | Next beacon target time for programming |
| evt | output | 4 | Event pulse per timer |
| tmr0_q | output | 16 | Next beacon target time |
| tmr1_q | output | 19 | DMA alert, 1/8 TU |
| tmr2_q | output | 19 | Software alert, 1/8 TU |
| tmr3_q | output | 16 | ATIM window end |
| win_ok | output | 1 | Timer window consistency flag |

## Verification
Event outputs are combinational from the timers and `tsf_tu`. Timer values change one clock edge after a match, write or program strobe. `win_ok` follows the timers combinationally, so it settles in that same post-edge cycle. The bench drives inputs on the falling edge. It reads `evt` 1 ns later, then reads timers and `win_ok` at the next falling edge, after exactly one rising edge. Each expected value is worked out by hand from the requirement, and each window expectation is computed with a separate model of the four-case test.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic {
    OPM_MASTER  = 1'b0,
    OPM_STATION = 1'b1
  } bt_opmode_e;
endpackage

// File: rtl/bt_timer_slot.sv
module bt_timer_slot #(
  parameter int TU_W = 16,
  parameter int FRAC = 0,
  localparam int W = TU_W + FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TU_W-1:0] tsf_tu,
  input  logic [W-1:0]  step,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          ld_en,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  q,
  output logic          evt
);
  logic hit;

  assign hit = (q[W-1:FRAC] == tsf_tu);
  assign evt = enable & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (ld_en)  q <= ld_val;
    else if (wr_en)  q <= wr_data;
    else if (evt)    q <= q + step;
  end

  // R2: a match with enable moves the timer by one step
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hit && !wr_en && !ld_en) |=> (q == $past(q + step)));
  // R3: no match, no change
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !wr_en && !ld_en) |=> $stable(q));
  // R5: disabled timers stay put
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_en && !ld_en) |=> $stable(q));
  // R6: write lands and beats advance
  assert_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld_en) |=> (q == $past(wr_data)));
  // R9: program load wins
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (q == $past(ld_val)));
endmodule

// File: rtl/bt_prog_calc.sv
module bt_prog_calc
  import bt_pkg::*;
#(
  parameter int TU_W     = 16,
  parameter int FRAC_W   = 3,
  parameter int DMA_LEAD = 2,
  parameter int SW_LEAD  = 10,
  localparam int WF = TU_W + FRAC_W,
  parameter logic [WF-1:0] STA_T1_INIT = WF'((1 << TU_W) - 1),
  parameter logic [WF-1:0] STA_T2_INIT = '1
) (
  input  bt_opmode_e      mode,
  input  logic [TU_W-1:0] nbtt,
  output logic [TU_W-1:0] t0,
  output logic [WF-1:0]   t1,
  output logic [WF-1:0]   t2,
  output logic [TU_W-1:0] t3
);
  localparam logic [TU_W-1:0] DMA_D = TU_W'(DMA_LEAD);
  localparam logic [TU_W-1:0] SW_D  = TU_W'(SW_LEAD);

  logic [TU_W-1:0] dma_tu, sw_tu;

  always_comb begin
    dma_tu = nbtt - DMA_D;
    sw_tu  = nbtt - SW_D;
    t0     = nbtt;
    t3     = nbtt + TU_W'(1);
    if (mode == OPM_STATION) begin
      t1 = STA_T1_INIT;
      t2 = STA_T2_INIT;
    end else begin
      t1 = {dma_tu, {FRAC_W{1'b0}}};
      t2 = {sw_tu, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/bt_window_pair.sv
module bt_window_pair #(
  parameter int TU_W = 16,
  parameter int WIN  = 1
) (
  input  logic [TU_W-1:0] a,
  input  logic [TU_W-1:0] b,
  input  logic [TU_W-1:0] ivl,
  output logic            ok
);
  localparam int SW = TU_W + 3;
  localparam logic signed [SW-1:0] EW   = SW'(WIN);
  localparam logic signed [SW-1:0] WRAP = SW'(1) << TU_W;

  logic signed [SW-1:0] ea, eb, eiv, eiw;

  always_comb begin
    ea  = $signed({3'b000, a});
    eb  = $signed({3'b000, b});
    eiv = $signed({3'b000, ivl});
    eiw = eiv - EW;
    ok  = ((eb - ea) == EW)
        | ((ea - eb) == eiw)
        | (((ea | WRAP) - eb) == eiw)
        | (((eb | WRAP) - ea) == EW);
  end
endmodule

// File: rtl/beacon_timer_bank.sv
module beacon_timer_bank
  import bt_pkg::*;
#(
  parameter int TU_W     = 16,
  parameter int FRAC_W   = 3,
  parameter int DMA_LEAD = 2,
  parameter int SW_LEAD  = 10,
  localparam int WF      = TU_W + FRAC_W,
  localparam int NTMR    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            sta_mode,
  input  logic [TU_W-1:0] bcn_ivl,
  input  logic [TU_W-1:0] tsf_tu,
  input  logic [NTMR-1:0] wr_en,
  input  logic [WF-1:0]   wr_data,
  input  logic            prog_en,
  input  logic [TU_W-1:0] prog_nbtt,
  output logic [NTMR-1:0] evt,
  output logic [TU_W-1:0] tmr0_q,
  output logic [WF-1:0]   tmr1_q,
  output logic [WF-1:0]   tmr2_q,
  output logic [TU_W-1:0] tmr3_q,
  output logic            win_ok
);
  bt_opmode_e      mode;
  logic [TU_W-1:0] ld_whole [2];
  logic [WF-1:0]   ld_frac  [2];
  logic [TU_W-1:0] q_whole  [2];
  logic [WF-1:0]   q_frac   [2];
  logic            ok_atim, ok_dma;

  assign mode = bt_opmode_e'(sta_mode);

  bt_prog_calc #(
    .TU_W(TU_W), .FRAC_W(FRAC_W), .DMA_LEAD(DMA_LEAD), .SW_LEAD(SW_LEAD)
  ) u_calc (
    .mode (mode),
    .nbtt (prog_nbtt),
    .t0   (ld_whole[0]),
    .t1   (ld_frac[0]),
    .t2   (ld_frac[1]),
    .t3   (ld_whole[1])
  );

  for (genvar i = 0; i < NTMR; i++) begin : g_slot
    if (i == 1 || i == 2) begin : g_frac
      bt_timer_slot #(.TU_W(TU_W), .FRAC(FRAC_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tsf_tu  (tsf_tu),
        .step    ({bcn_ivl, {FRAC_W{1'b0}}}),
        .wr_en   (wr_en[i]),
        .wr_data (wr_data),
        .ld_en   (prog_en),
        .ld_val  (ld_frac[i-1]),
        .q       (q_frac[i-1]),
        .evt     (evt[i])
      );
    end else begin : g_whole
      localparam int K = (i == 0) ? 0 : 1;
      bt_timer_slot #(.TU_W(TU_W), .FRAC(0)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tsf_tu  (tsf_tu),
        .step    (bcn_ivl),
        .wr_en   (wr_en[i]),
        .wr_data (wr_data[TU_W-1:0]),
        .ld_en   (prog_en),
        .ld_val  (ld_whole[K]),
        .q       (q_whole[K]),
        .evt     (evt[i])
      );
    end
  end

  assign tmr0_q = q_whole[0];
  assign tmr3_q = q_whole[1];
  assign tmr1_q = q_frac[0];
  assign tmr2_q = q_frac[1];

  bt_window_pair #(.TU_W(TU_W), .WIN(1)) u_win_atim (
    .a (tmr0_q), .b (tmr3_q), .ivl (bcn_ivl), .ok (ok_atim)
  );

  bt_window_pair #(.TU_W(TU_W), .WIN(DMA_LEAD)) u_win_dma (
    .a (tmr1_q[WF-1:FRAC_W]), .b (tmr0_q), .ivl (bcn_ivl), .ok (ok_dma)
  );

  assign win_ok = ok_atim & ok_dma;

  // R5: no event leaves the bank while disabled
  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (evt == '0));
  // R2: next beacon event only on an exact TU match
  assert_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> (tmr0_q == tsf_tu));
  // R7 R10: master-mode programming yields a consistent bank
  assert_prog_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !sta_mode) |=> win_ok);
  // R7: ATIM end follows next beacon by one
  assert_atim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> (tmr3_q == $past(prog_nbtt) + TU_W'(1)));
  // R8: station programming parks the software alert at all ones
  assert_sta_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && sta_mode) |=> (tmr2_q == '1));
endmodule

// File: tb/beacon_timer_bank_bench.sv
`timescale 1ns/1ps
module beacon_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        sta_mode = 1'b0;
  logic [15:0] bcn_ivl = 16'd100;
  logic [15:0] tsf_tu = 16'd0;
  logic [3:0]  wr_en = 4'd0;
  logic [18:0] wr_data = 19'd0;
  logic        prog_en = 1'b0;
  logic [15:0] prog_nbtt = 16'd0;
  logic [3:0]  evt;
  logic [15:0] tmr0_q, tmr3_q;
  logic [18:0] tmr1_q, tmr2_q;
  logic        win_ok;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  beacon_timer_bank u_beacon_timer_bank (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sta_mode(sta_mode),
    .bcn_ivl(bcn_ivl), .tsf_tu(tsf_tu), .wr_en(wr_en), .wr_data(wr_data),
    .prog_en(prog_en), .prog_nbtt(prog_nbtt), .evt(evt),
    .tmr0_q(tmr0_q), .tmr1_q(tmr1_q), .tmr2_q(tmr2_q), .tmr3_q(tmr3_q),
    .win_ok(win_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit pair_ok(int a, int b, int w, int ivl);
    return (b - a == w) || (a - b == ivl - w) ||
           ((a | 65536) - b == ivl - w) || ((b | 65536) - a == w);
  endfunction

  function automatic bit model_win();
    return pair_ok(int'(tmr0_q), int'(tmr3_q), 1, int'(bcn_ivl)) &&
           pair_ok(int'(tmr1_q >> 3), int'(tmr0_q), 2, int'(bcn_ivl));
  endfunction

  task automatic wr_tmr(input int idx, input logic [18:0] d);
    wr_en = 4'b0001 << idx;
    wr_data = d;
    @(negedge clk);
    wr_en = 4'd0;
  endtask

  task automatic hit_chk(input logic [15:0] v, input logic [3:0] exp_evt, input string req);
    tsf_tu = v;
    #1;
    chk(req, 32'(evt), 32'(exp_evt));
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 t0", 32'(tmr0_q), 0);
    chk("R1 t1", 32'(tmr1_q), 0);
    chk("R1 t2", 32'(tmr2_q), 0);
    chk("R1 t3", 32'(tmr3_q), 0);
    chk("R1 evt", 32'(evt), 0);
    chk("R10 win reset", 32'(win_ok), 0);
  endtask

  task automatic t_prog_master;
    sta_mode = 1'b0; prog_nbtt = 16'd100; prog_en = 1'b1;
    @(negedge clk);
    prog_en = 1'b0;
    chk("R7 t0", 32'(tmr0_q), 100);
    chk("R7 t1", 32'(tmr1_q), 98 * 8);
    chk("R7 t2", 32'(tmr2_q), 90 * 8);
    chk("R7 t3", 32'(tmr3_q), 101);
    chk("R10 win after prog", 32'(win_ok), 1);
  endtask

  task automatic t_advance;
    enable = 1'b1;
    hit_chk(16'd90, 4'b0100, "R2 evt2");
    chk("R2 t2 step", 32'(tmr2_q), 720 + 800);
    chk("R2 evt2 single", 32'(evt), 0);
    hit_chk(16'd98, 4'b0010, "R2 evt1");
    chk("R2 t1 step", 32'(tmr1_q), 784 + 800);
    hit_chk(16'd100, 4'b0001, "R2 evt0");
    chk("R2 t0 step", 32'(tmr0_q), 200);
    chk("R10 win case2", 32'(win_ok), 32'(model_win()));
    hit_chk(16'd101, 4'b1000, "R2 evt3");
    chk("R2 t3 step", 32'(tmr3_q), 201);
    chk("R10 win realigned", 32'(win_ok), 1);
  endtask

  task automatic t_jump;
    hit_chk(16'd250, 4'b0000, "R3 no evt past");
    chk("R3 t0 held", 32'(tmr0_q), 200);
    chk("R3 t3 held", 32'(tmr3_q), 201);
    hit_chk(16'd201, 4'b1000, "R11 evt3 only");
    chk("R11 t3", 32'(tmr3_q), 301);
    chk("R11 t0 left", 32'(tmr0_q), 200);
    chk("R11 win drift", 32'(win_ok), 0);
  endtask

  task automatic t_disabled;
    enable = 1'b0;
    hit_chk(16'd200, 4'b0000, "R5 no evt");
    chk("R5 t0 frozen", 32'(tmr0_q), 200);
    wr_tmr(0, 19'd555);
    chk("R5 R6 write while off", 32'(tmr0_q), 555);
  endtask

  task automatic t_write_prio;
    enable = 1'b1; tsf_tu = 16'd555;
    wr_tmr(0, 19'h7FC00);
    chk("R6 write beats advance", 32'(tmr0_q), 32'h0FC00);
    tsf_tu = 16'h7777;
    @(negedge clk);
  endtask

  task automatic t_wrap;
    bcn_ivl = 16'h0020;
    wr_tmr(0, 19'h0FFF0);
    hit_chk(16'hFFF0, 4'b0001, "R4 evt0");
    chk("R4 t0 wrap", 32'(tmr0_q), 32'h0010);
    wr_tmr(1, 19'h7FFF8);
    hit_chk(16'hFFFF, 4'b0010, "R4 evt1");
    chk("R4 t1 wrap", 32'(tmr1_q), 32'h000F8);
  endtask

  task automatic t_windows;
    enable = 1'b0;
    wr_tmr(0, 19'h00010); wr_tmr(3, 19'h0FFF1); wr_tmr(1, 19'h00070);
    chk("R10 case3 model", 32'(model_win()), 1);
    chk("R10 case3", 32'(win_ok), 1);
    wr_tmr(0, 19'h0FFFF); wr_tmr(3, 19'h00000); wr_tmr(1, 19'h7FFE8);
    chk("R10 case4", 32'(win_ok), 1);
    wr_tmr(3, 19'h00002);
    chk("R10 bad window", 32'(win_ok), 0);
  endtask

  task automatic t_prog_station;
    sta_mode = 1'b1; prog_nbtt = 16'd500; prog_en = 1'b1;
    wr_en = 4'hF; wr_data = 19'd0;
    @(negedge clk);
    prog_en = 1'b0; wr_en = 4'd0;
    chk("R8 R9 t0", 32'(tmr0_q), 500);
    chk("R8 t1", 32'(tmr1_q), 32'h0FFFF);
    chk("R8 t2", 32'(tmr2_q), 32'h7FFFF);
    chk("R8 R9 t3", 32'(tmr3_q), 501);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_prog_master();
    t_advance();
    t_jump();
    t_disabled();
    t_write_prio();
    t_wrap();
    t_windows();
    t_prog_station();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule